// File: doc/BRIEF.md
# GPIO Pad Controller with Interrupts

The block manages a group of general-purpose pads (32 by default) behind a simple register bus. Each pad has two 32-bit configuration words. The first word drives the pad: the output level and the driver enable. It also gates the receive path, optionally inverts the received signal, and picks how that signal turns into an interrupt event. The second word only stores termination and standby codes for logic outside the block.

Shared registers hold the per-pin pad owner codes, the per-pin host-software ownership bits, the interrupt status and the interrupt enable. Pad inputs pass through a two-flop synchroniser before software can read them or event detection can use them.

An event sets a status bit. The status bits are cleared by writing ones to them. A single level interrupt output is high whenever any pin has both its status bit and its enable bit set. Software uses the block by first configuring a pad as input-only, then selecting edge or level detection with optional inversion, then enabling the pin's interrupt. Its handler clears the status bits it has served.

Top module: `gpio_padctl`

## Requirements
- R1: After reset, every configuration word 0 reads 0x04000100 with all pad inputs low: driver off, receive on, event mode 2. Every configuration word 1 reads 0, and status and enable read 0. The interrupt output is low and pad_oe is all zero.
- R2: Word 0 bit 0 drives pad_out for its pin, and pad_oe is high exactly when word 0 bit 8 is 0. Word 0 bit 1 reads the pad input after a two-flop synchroniser, and writes to bit 1 are ignored.
- R3: Pad p has word 0 at 0x100 + 16·p and word 1 at 0x100 + 16·p + 4. In word 0 only bits 0, 8, 9, 23 and 26:25 are writable, and all other bits read 0 except the input level in bit 1. In word 1 bits 17:8 are stored and all other bits read 0.
- R4: With word 0 bits 26:25 = 1 (edge), the pin's status bit sets on a rising edge of the conditioned input. A falling edge leaves the bit unchanged. Status is at 0x20, bit p for pin p.
- R5: Word 0 bit 23 inverts the synchronised input before event detection. In edge mode a falling pad edge then triggers, and in level mode a low pad does. A configuration change that raises the conditioned input counts as a rising edge.
- R6: With bits 26:25 = 0 (level), the status bit sets on every cycle the conditioned input is high. A clear written while the level persists has no lasting effect, and a set in the same cycle as a clear wins.
- R7: Event modes 2 and 3 force the event input to zero, so the pin never sets its status bit.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R9: A pin sets no status bit while its word 0 bit 9 (receive disable) is 1 or its bit 8 (transmit disable) is 0.
- R10: The enable register at 0x40 holds one bit per pin. irq is high exactly when some pin has both its status bit and its enable bit set.
- R11: Owner register k at 4·k holds the 2-bit owner codes of pins 8k..8k+7, pin 8k+j at bits 4j+1:4j, and its other bits read 0. The host ownership register at 0x10 stores one bit per pin. Both are storage only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; bus_rdata is valid after the next clock edge |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | NPINS | Asynchronous pad input levels |
| pad_out | output | NPINS | Driven output levels |
| pad_oe | output | NPINS | Output driver enables |
| irq | output | 1 | Level interrupt output |

## Verification
The assertions check four rules on every cycle. Status bits never appear for a pin whose event mode is forced to zero or whose receive path is gated off. The interrupt never rises while every enable bit is clear. The pad outputs move only after a bus write. Only the bench scenarios can show the rest: the field positions and address map, the three-edge latency from pad to status, edge against level behaviour with and without inversion, a clear losing to a persisting level, and the write-one-to-clear semantics.

// File: rtl/gpio_padctl_pkg.sv
package gpio_padctl_pkg;
    localparam int REG_W      = 32;
    localparam int OWN_BASE   = 'h000;
    localparam int HOWN_OFS   = 'h010;
    localparam int STS_OFS    = 'h020;
    localparam int EN_OFS     = STS_OFS + 'h20;
    localparam int PAD_BASE   = 'h100;
    localparam int PAD_STRIDE = 16;
    localparam int CFG1_OFS   = 4;
    localparam int PINS_PER_OWN = 8;
    localparam int OWN_STRIDE   = 4;

    // word 0 fields
    localparam int B_TXLVL  = 0;
    localparam int B_RXLVL  = 1;
    localparam int B_TXOFF  = 8;
    localparam int B_RXOFF  = 9;
    localparam int B_INV    = 23;
    localparam int B_EVM    = 25;
    // word 1 fields
    localparam int B_SBTERM = 8;
    localparam int B_TERM   = 10;
    localparam int B_SBST   = 14;

    typedef enum logic [1:0] {
        EV_LEVEL = 2'd0,
        EV_EDGE  = 2'd1,
        EV_ZERO  = 2'd2,
        EV_ZERO2 = 2'd3
    } ev_mode_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d.s1 = din;
        sy_d.s2 = sy_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign dout = sy_q.s2;
endmodule

// File: rtl/gpio_evt_cell.sv
module gpio_evt_cell
    import gpio_padctl_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     rx_sync,
    input  logic     inv,
    input  ev_mode_e mode,
    input  logic     live,
    input  logic     allow,
    output logic     evt
);
    logic prev_d, prev_q;
    logic cond;

    always_comb begin
        cond   = live & (rx_sync ^ inv);
        prev_d = cond;
        unique case (mode)
            EV_EDGE:  evt = allow & cond & ~prev_q;
            EV_LEVEL: evt = allow & cond;
            default:  evt = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/gpio_padctl.sv
module gpio_padctl
    import gpio_padctl_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic              irq
);
    localparam int OWN_REGS = (NPINS + PINS_PER_OWN - 1) / PINS_PER_OWN;

    typedef struct packed {
        logic [NPINS-1:0]      txlvl;
        logic [NPINS-1:0]      txoff;
        logic [NPINS-1:0]      rxoff;
        logic [NPINS-1:0]      inv;
        logic [NPINS-1:0][1:0] evm;
        logic [NPINS-1:0][1:0] sbterm;
        logic [NPINS-1:0][3:0] term;
        logic [NPINS-1:0][3:0] sbst;
        logic [NPINS-1:0][1:0] owner;
        logic [NPINS-1:0]      hown;
        logic [NPINS-1:0]      status;
        logic [NPINS-1:0]      enable;
        logic [31:0]           rdata;
    } state_t;

    state_t st_d, st_q;

    logic [NPINS-1:0] rx_sync;
    logic [NPINS-1:0] evt_vec;
    logic [NPINS-1:0] allow_vec;
    logic [NPINS-1:0] live_vec;
    logic [NPINS-1:0] sts_vec;
    logic [NPINS-1:0] en_vec;
    logic [NPINS-1:0] clr_vec;
    logic [31:0]      rd_val;

    gpio_in_sync #(.W(NPINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pad_in),
        .dout  (rx_sync)
    );

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        assign allow_vec[g] = ~st_q.rxoff[g] & st_q.txoff[g];
        assign live_vec[g]  = (st_q.evm[g] == EV_LEVEL) || (st_q.evm[g] == EV_EDGE);
        gpio_evt_cell u_evt (
            .clk     (clk),
            .rst_n   (rst_n),
            .rx_sync (rx_sync[g]),
            .inv     (st_q.inv[g]),
            .mode    (ev_mode_e'(st_q.evm[g])),
            .live    (live_vec[g]),
            .allow   (allow_vec[g]),
            .evt     (evt_vec[g])
        );
    end

    always_comb begin
        st_d = st_q;

        // status: write-one-to-clear, a new event wins over a clear
        clr_vec = (bus_wr && bus_addr == ADDR_W'(STS_OFS)) ? bus_wdata[NPINS-1:0] : '0;
        st_d.status = (st_q.status & ~clr_vec) | evt_vec;

        if (bus_wr && bus_addr == ADDR_W'(HOWN_OFS)) st_d.hown   = bus_wdata[NPINS-1:0];
        if (bus_wr && bus_addr == ADDR_W'(EN_OFS))   st_d.enable = bus_wdata[NPINS-1:0];

        for (int p = 0; p < NPINS; p++) begin
            if (bus_wr && bus_addr == ADDR_W'(PAD_BASE + p * PAD_STRIDE)) begin
                st_d.txlvl[p] = bus_wdata[B_TXLVL];
                st_d.txoff[p] = bus_wdata[B_TXOFF];
                st_d.rxoff[p] = bus_wdata[B_RXOFF];
                st_d.inv[p]   = bus_wdata[B_INV];
                st_d.evm[p]   = bus_wdata[B_EVM +: 2];
            end
            if (bus_wr && bus_addr == ADDR_W'(PAD_BASE + p * PAD_STRIDE + CFG1_OFS)) begin
                st_d.sbterm[p] = bus_wdata[B_SBTERM +: 2];
                st_d.term[p]   = bus_wdata[B_TERM +: 4];
                st_d.sbst[p]   = bus_wdata[B_SBST +: 4];
            end
            if (bus_wr && bus_addr == ADDR_W'(OWN_BASE + (p / PINS_PER_OWN) * 4)) begin
                st_d.owner[p] = bus_wdata[(p % PINS_PER_OWN) * OWN_STRIDE +: 2];
            end
        end

        // read multiplexer
        rd_val = '0;
        if (bus_addr == ADDR_W'(HOWN_OFS)) rd_val[NPINS-1:0] = st_q.hown;
        if (bus_addr == ADDR_W'(STS_OFS))  rd_val[NPINS-1:0] = st_q.status;
        if (bus_addr == ADDR_W'(EN_OFS))   rd_val[NPINS-1:0] = st_q.enable;
        for (int k = 0; k < OWN_REGS; k++) begin
            if (bus_addr == ADDR_W'(OWN_BASE + k * 4)) begin
                for (int j = 0; j < PINS_PER_OWN; j++) begin
                    if (k * PINS_PER_OWN + j < NPINS)
                        rd_val[j * OWN_STRIDE +: 2] = st_q.owner[k * PINS_PER_OWN + j];
                end
            end
        end
        for (int p = 0; p < NPINS; p++) begin
            if (bus_addr == ADDR_W'(PAD_BASE + p * PAD_STRIDE)) begin
                rd_val[B_TXLVL]    = st_q.txlvl[p];
                rd_val[B_RXLVL]    = rx_sync[p];
                rd_val[B_TXOFF]    = st_q.txoff[p];
                rd_val[B_RXOFF]    = st_q.rxoff[p];
                rd_val[B_INV]      = st_q.inv[p];
                rd_val[B_EVM +: 2] = st_q.evm[p];
            end
            if (bus_addr == ADDR_W'(PAD_BASE + p * PAD_STRIDE + CFG1_OFS)) begin
                rd_val[B_SBTERM +: 2] = st_q.sbterm[p];
                rd_val[B_TERM +: 4]   = st_q.term[p];
                rd_val[B_SBST +: 4]   = st_q.sbst[p];
            end
        end
        if (bus_rd) st_d.rdata = rd_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.txoff <= '1;
            for (int p = 0; p < NPINS; p++) st_q.evm[p] <= EV_ZERO;
        end else begin
            st_q <= st_d;
        end
    end

    assign sts_vec   = st_q.status;
    assign en_vec    = st_q.enable;
    assign bus_rdata = st_q.rdata;
    assign pad_out   = st_q.txlvl;
    assign pad_oe    = ~st_q.txoff;
    assign irq       = |(sts_vec & en_vec);
endmodule

// File: rtl/gpio_padctl_sva.sv
module gpio_padctl_sva #(
    parameter int NPINS = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [NPINS-1:0] pad_out,
    input logic [NPINS-1:0] pad_oe,
    input logic             irq,
    input logic [NPINS-1:0] sts_vec,
    input logic [NPINS-1:0] en_vec,
    input logic [NPINS-1:0] allow_vec,
    input logic [NPINS-1:0] live_vec
);
    // R1: status and enable are empty when reset is released
    a_r1_clean_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (sts_vec == '0 && en_vec == '0));

    // R2: pad outputs move only after a bus write
    a_r2_outputs_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_wr) |-> ($stable(pad_out) && $stable(pad_oe)));

    // R7: no new status bit on a pin whose event input is forced to zero
    a_r7_forced_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((sts_vec & ~$past(sts_vec)) & ~$past(live_vec)) == '0);

    // R9: no new status bit on a pin with gated receive or an active driver
    a_r9_gated_pin: assert property (@(posedge clk) disable iff (!rst_n)
        ((sts_vec & ~$past(sts_vec)) & ~$past(allow_vec)) == '0);

    // R10: interrupt needs at least one enable bit
    a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (en_vec != '0));
endmodule

bind gpio_padctl gpio_padctl_sva #(.NPINS(NPINS)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .irq       (irq),
    .sts_vec   (sts_vec),
    .en_vec    (en_vec),
    .allow_vec (allow_vec),
    .live_vec  (live_vec)
);

// File: tb/tb_gpio_padctl.sv
module tb_gpio_padctl;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 32;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] pad_oe;
    logic          irq;

    int n_chk = 0;
    int n_fail = 0;
    logic rd_seen = 1'b0;
    logic [31:0] q_exp[$];
    string       q_tag[$];
    logic [31:0] m_exp;
    string       m_tag;

    gpio_padctl #(.NPINS(NP), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) rd_seen <= bus_rd;

    // monitor: pops expected read data and compares
    always @(negedge clk) begin
        if (rd_seen) begin
            m_exp = q_exp.pop_front();
            m_tag = q_tag.pop_front();
            n_chk++;
            if (bus_rdata !== m_exp) begin
                n_fail++;
                $display("FAIL %s: read 0x%08h expected 0x%08h", m_tag, bus_rdata, m_exp);
            end
        end
    end

    function automatic logic [AW-1:0] w0(int p);
        return AW'('h100 + 16 * p);
    endfunction

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [AW-1:0] a, logic [31:0] e, string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        q_exp.push_back(e);
        q_tag.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] e);
        n_chk++;
        if (act !== e) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, e);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: expired, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 pad_oe", pad_oe, 32'd0);
        rd(w0(0), 32'h0400_0100, "R1 word0 pin0");
        rd(w0(0) + 4, 32'h0, "R1 word1 pin0");
        rd('h20, 32'h0, "R1 status");
        rd('h40, 32'h0, "R1 enable");

        // R3 writable fields
        wr(w0(5), 32'hFFFF_FFFF);
        rd(w0(5), 32'h0680_0301, "R3 word0 mask");
        wr(w0(5) + 4, 32'hFFFF_FFFF);
        rd(w0(5) + 4, 32'h0003_FF00, "R3 word1 mask");
        wr(w0(31) + 4, 32'h0001_5500);
        rd(w0(31) + 4, 32'h0001_5500, "R3 word1 last pin");
        // R2 output and driver enable
        chk("R2 pad_out", {31'd0, pad_out[5]}, 32'd1);
        chk("R2 pad_oe off", {31'd0, pad_oe[5]}, 32'd0);
        wr(w0(5), 32'h0000_0001);
        chk("R2 pad_oe on", {31'd0, pad_oe[5]}, 32'd1);
        // R2 input level, R7 mode 2 quiet
        pad_in[7] = 1'b1;
        idle(4);
        rd(w0(7), 32'h0400_0102, "R2 input level");
        rd('h20, 32'h0, "R7 mode 2 no event");

        // R4 edge mode
        wr('h40, 32'hFFFF_FFFF);
        wr(w0(3), 32'h0200_0100);
        pad_in[3] = 1'b1;
        idle(5);
        rd('h20, 32'h0000_0008, "R4 rising edge");
        chk("R10 irq on", {31'd0, irq}, 32'd1);
        wr('h20, 32'hFFFF_FFF7);
        rd('h20, 32'h0000_0008, "R8 write zero keeps");
        wr('h20, 32'h0000_0008);
        rd('h20, 32'h0, "R8 write one clears");
        chk("R10 irq off", {31'd0, irq}, 32'd0);
        pad_in[3] = 1'b0;
        idle(5);
        rd('h20, 32'h0, "R4 falling ignored");

        // R5 inverted edge
        wr(w0(4), 32'h0280_0100);
        idle(3);
        rd('h20, 32'h0000_0010, "R5 config raises conditioned input");
        wr('h20, 32'h0000_0010);
        pad_in[4] = 1'b1;
        idle(5);
        rd('h20, 32'h0, "R5 rising pad ignored");
        pad_in[4] = 1'b0;
        idle(5);
        rd('h20, 32'h0000_0010, "R5 falling pad triggers");
        wr(w0(4), 32'h0400_0100);
        wr('h20, 32'h0000_0010);
        rd('h20, 32'h0, "R5 cleared");

        // R6 level mode
        wr(w0(6), 32'h0000_0100);
        pad_in[6] = 1'b1;
        idle(5);
        rd('h20, 32'h0000_0040, "R6 level set");
        wr('h20, 32'h0000_0040);
        rd('h20, 32'h0000_0040, "R6 clear has no lasting effect");
        pad_in[6] = 1'b0;
        idle(4);
        wr('h20, 32'h0000_0040);
        rd('h20, 32'h0, "R6 cleared after level drops");
        wr(w0(6), 32'h0080_0100);
        idle(3);
        rd('h20, 32'h0000_0040, "R5 inverted level on low pad");
        wr(w0(6), 32'h0400_0100);
        wr('h20, 32'h0000_0040);
        rd('h20, 32'h0, "R6 quiet again");

        // R7 mode 3
        wr(w0(2), 32'h0600_0100);
        pad_in[2] = 1'b1;
        idle(5);
        rd('h20, 32'h0, "R7 mode 3 no event");

        // R9 gating
        wr(w0(8), 32'h0200_0300);
        pad_in[8] = 1'b1;
        idle(5);
        rd('h20, 32'h0, "R9 receive disabled");
        wr(w0(9), 32'h0200_0000);
        pad_in[9] = 1'b1;
        idle(5);
        rd('h20, 32'h0, "R9 driver enabled");
        chk("R9 pad_oe pin9", {31'd0, pad_oe[9]}, 32'd1);

        // R10 enable masking
        wr('h40, 32'h0);
        pad_in[3] = 1'b1;
        idle(5);
        rd('h20, 32'h0000_0008, "R10 status without enable");
        chk("R10 irq masked", {31'd0, irq}, 32'd0);
        rd('h40, 32'h0, "R10 enable reads back");
        wr('h40, 32'h0000_0008);
        chk("R10 irq after enable", {31'd0, irq}, 32'd1);
        wr('h20, 32'h0000_0008);
        chk("R10 irq after clear", {31'd0, irq}, 32'd0);

        // R11 ownership storage
        wr('h04, 32'hFFFF_FFFF);
        rd('h04, 32'h3333_3333, "R11 owner fields");
        rd('h00, 32'h0, "R11 other owner reg");
        wr('h10, 32'hA5A5_A5A5);
        rd('h10, 32'hA5A5_A5A5, "R11 host ownership");

        idle(3);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule